// File: doc/BRIEF.md
# Masked Multi-Entry Frame Classifier

This block sorts received frames into accept or drop and picks a receive ring for each accepted frame. It holds a bank of programmable entries. Each entry has a pattern for the opening bytes of a frame, a per-byte ignore mask, a per-bit compare mask over the first two bytes, a ring number and an enable bit. Frame bytes arrive one per cycle with start and end markers. Every enabled entry is checked against each byte as it arrives, and all entries are checked at the same time.

The block gives one verdict per frame. The verdict comes when the last byte of the comparison window arrives, or when the frame ends, whichever happens first. The verdict is a one-cycle pulse that carries an accept flag, the ring and the number of the winning entry. An entry that ignores every byte matches every frame, so it acts as a catch-all. Software programs station, broadcast and multicast addresses by comparing only the first six bytes. It turns an entry off before it rewrites that entry and turns it back on afterwards.

Top module: `pf_filter`

## Requirements
- R1: After reset every entry is disabled, all pattern, mask, ring and enable storage reads as zero, and `res_valid` is low. A frame sent before any programming is rejected.
- R2: A write is decoded from `cfg_addr` as follows: bits [11:9] give the kind, bits [8:4] give the entry and bits [3:0] give the word. The kinds are 0 = pattern word, 1 = byte-mask word, 2 = bit mask, 3 = ring selector and 4 = enable vector. For kind 4 the entry and word fields are ignored, and bit e of `cfg_wdata` enables entry e. Writes of kinds 0 to 3 that name an entry number of NUM_ENTRIES or higher change nothing.
- R3: In pattern word w, bits [8i+7:8i] hold window byte 4w+i. The first frame byte is byte 0.
- R4: In byte-mask word w, bit i covers window byte 32w+i. When the bit is set, that byte is not compared.
- R5: Bit-mask bits [7:0] cover the bits of byte 0 and bits [15:8] cover the bits of byte 1. A bit compares only while its mask bit is 1. Bytes 2 and up compare all eight bits.
- R6: The verdict pulse (`res_valid`) comes exactly one cycle after the byte that completes the 64-byte window or carries `rx_eof`, whichever comes first. There is one pulse per frame. Bytes after the verdict are ignored until the next `rx_sof`. An `rx_sof` in the middle of a frame starts a new frame.
- R7: An entry fails if a byte position it does not ignore lies past the end of a frame shorter than the window.
- R8: An entry whose byte mask ignores all 64 bytes matches every frame, including a frame of one byte.
- R9: When more than one enabled entry matches, the lowest-numbered one gives `res_ring` and `res_entry`.
- R10: A disabled entry never matches. The enable vector is sampled in the cycle of the deciding byte.
- R11: A rejected verdict shows `res_accept`=0, `res_ring`=0 and `res_entry`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Write address: kind, entry, word |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | Present byte is the first of a frame |
| rx_eof | input | 1 | Present byte is the last of a frame |
| rx_byte | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle verdict pulse |
| res_accept | output | 1 | Frame accepted |
| res_ring | output | 2 | Ring chosen by the winning entry |
| res_entry | output | 5 | Number of the winning entry |

## Verification
The bench targets these corner cases:
- **Frame length around the required bytes.** Frames are sent that end just before, and exactly at, the last byte an entry needs. A design that judged only the bytes received would accept the short frames.
- **Window boundary.** One entry checks only byte 63. A verdict that came one byte early or late would miss that byte or report after the window.
- **Entry overlap.** A catch-all entry is enabled together with exact-address entries. A wrong priority encoder would report the catch-all instead of the lower-numbered match.
- **Out-of-range entry number.** A write names entry 17. An address decoder that truncated the entry field would overwrite entry 1.
- **Bit mask.** Frames differ only in a bit that is masked, or in a bit that is not. A design with the bit mask reversed would accept the wrong frame of the pair.
- **Restarts.** A frame is restarted in its middle by a new start marker. A design that did not restart cleanly would give a second pulse or a pulse at the wrong time.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int PF_WORD_W = 32;
    localparam int PF_KIND_W = 3;

    typedef enum logic [PF_KIND_W-1:0] {
        PF_K_PAT      = 3'd0,
        PF_K_BYTEMASK = 3'd1,
        PF_K_BITMASK  = 3'd2,
        PF_K_RING     = 3'd3,
        PF_K_ENABLE   = 3'd4
    } pf_kind_e;

endpackage

// File: rtl/pf_cfg_bank.sv
module pf_cfg_bank
    import pf_pkg::*;
#(
    parameter  int NE     = 17,
    parameter  int WIN    = 64,
    parameter  int SEL_W  = 2,
    parameter  int BM_W   = 16,
    localparam int ENT_W  = $clog2(NE),
    localparam int WSEL_W = $clog2(WIN / 4),
    localparam int ADDR_W = PF_KIND_W + ENT_W + WSEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [PF_WORD_W-1:0]          wr_data,
    output logic [NE-1:0][WIN*8-1:0]      pat_o,
    output logic [NE-1:0][WIN-1:0]        bmask_o,
    output logic [NE-1:0][BM_W-1:0]       bitm_o,
    output logic [NE-1:0][SEL_W-1:0]      ring_o,
    output logic [NE-1:0]                 en_o
);

    localparam int PAT_WORDS  = WIN / 4;
    localparam int MASK_WORDS = WIN / PF_WORD_W;

    typedef struct packed {
        logic [NE-1:0][WIN*8-1:0] pat;
        logic [NE-1:0][WIN-1:0]   bmask;
        logic [NE-1:0][BM_W-1:0]  bitm;
        logic [NE-1:0][SEL_W-1:0] ring;
        logic [NE-1:0]            en;
    } cfg_t;

    cfg_t q, d;

    pf_kind_e           kind;
    logic [ENT_W-1:0]   ent;
    logic [WSEL_W-1:0]  wsel;

    assign kind = pf_kind_e'(wr_addr[ADDR_W-1 -: PF_KIND_W]);
    assign ent  = wr_addr[WSEL_W +: ENT_W];
    assign wsel = wr_addr[WSEL_W-1:0];

    always_comb begin
        d = q;
        if (wr_en) begin
            if (kind == PF_K_ENABLE) begin
                d.en = wr_data[NE-1:0];
            end else if (int'(ent) < NE) begin
                case (kind)
                    PF_K_PAT: begin
                        if (int'(wsel) < PAT_WORDS)
                            d.pat[ent][int'(wsel)*PF_WORD_W +: PF_WORD_W] = wr_data;
                    end
                    PF_K_BYTEMASK: begin
                        if (int'(wsel) < MASK_WORDS)
                            d.bmask[ent][int'(wsel)*PF_WORD_W +: PF_WORD_W] = wr_data;
                    end
                    PF_K_BITMASK: d.bitm[ent] = wr_data[BM_W-1:0];
                    PF_K_RING:    d.ring[ent] = wr_data[SEL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pat_o   = q.pat;
    assign bmask_o = q.bmask;
    assign bitm_o  = q.bitm;
    assign ring_o  = q.ring;
    assign en_o    = q.en;

    // R2: the enable vector takes the written word on the next cycle
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == PF_K_ENABLE) |=> (en_o == $past(wr_data[NE-1:0])));

    // R2: a write naming an entry past the bank leaves all storage alone
    a_r2_far_entry_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind != PF_K_ENABLE && int'(ent) >= NE) |=> $stable(q));

endmodule

// File: rtl/pf_entry_eval.sv
module pf_entry_eval #(
    parameter  int WIN   = 64,
    parameter  int BM_W  = 16,
    localparam int POS_W = $clog2(WIN)
) (
    input  logic [WIN*8-1:0] pat,
    input  logic [WIN-1:0]   bmask,
    input  logic [BM_W-1:0]  bitm,
    input  logic [POS_W-1:0] pos,
    input  logic [7:0]       data,
    input  logic             ok_in,
    output logic             ok_next,
    output logic             ok_final
);

    localparam int BM_BYTES = BM_W / 8;

    logic [7:0]     want;
    logic [7:0]     care;
    logic           byte_hit;
    logic [WIN-1:0] seen;

    always_comb begin
        want = pat[int'(pos)*8 +: 8];
        care = 8'hFF;
        for (int b = 0; b < BM_BYTES; b++) begin
            if (int'(pos) == b) care = bitm[b*8 +: 8];
        end
        byte_hit = bmask[pos] | (((data ^ want) & care) == 8'h00);
        seen     = {WIN{1'b1}} >> (WIN - 1 - int'(pos));
        ok_next  = ok_in & byte_hit;
        ok_final = ok_next & (&(bmask | seen));
    end

endmodule

// File: rtl/pf_pick.sv
module pf_pick #(
    parameter  int NE    = 17,
    parameter  int SEL_W = 2,
    localparam int IDX_W = $clog2(NE)
) (
    input  logic [NE-1:0]            hits,
    input  logic [NE-1:0][SEL_W-1:0] ring_tab,
    output logic                     any,
    output logic [IDX_W-1:0]         idx,
    output logic [SEL_W-1:0]         ring
);

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        ring = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                ring = ring_tab[i];
            end
        end
    end

endmodule

// File: rtl/pf_filter.sv
module pf_filter
    import pf_pkg::*;
#(
    parameter  int NUM_ENTRIES  = 17,
    parameter  int WINDOW_BYTES = 64,
    parameter  int SEL_W        = 2,
    parameter  int BITMASK_W    = 16,
    localparam int IDX_W        = $clog2(NUM_ENTRIES),
    localparam int POS_W        = $clog2(WINDOW_BYTES),
    localparam int ADDR_W       = PF_KIND_W + IDX_W + $clog2(WINDOW_BYTES / 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [PF_WORD_W-1:0] cfg_wdata,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_byte,
    output logic                 res_valid,
    output logic                 res_accept,
    output logic [SEL_W-1:0]     res_ring,
    output logic [IDX_W-1:0]     res_entry
);

    localparam int NE  = NUM_ENTRIES;
    localparam int WIN = WINDOW_BYTES;

    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
        logic [NE-1:0]    ok;
        logic             rvalid;
        logic             raccept;
        logic [SEL_W-1:0] rring;
        logic [IDX_W-1:0] rentry;
    } st_t;

    st_t q, d;

    logic [NE-1:0][WIN*8-1:0]     pat_w;
    logic [NE-1:0][WIN-1:0]       bmask_w;
    logic [NE-1:0][BITMASK_W-1:0] bitm_w;
    logic [NE-1:0][SEL_W-1:0]     ring_w;
    logic [NE-1:0]                en_w;

    logic             take;
    logic [POS_W-1:0] cur_pos;
    logic [NE-1:0]    base_ok;
    logic [NE-1:0]    ok_next;
    logic [NE-1:0]    ok_fin;
    logic [NE-1:0]    hits;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [SEL_W-1:0] pick_ring;

    pf_cfg_bank #(
        .NE(NE), .WIN(WIN), .SEL_W(SEL_W), .BM_W(BITMASK_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .pat_o(pat_w), .bmask_o(bmask_w), .bitm_o(bitm_w),
        .ring_o(ring_w), .en_o(en_w)
    );

    assign take    = rx_valid & (rx_sof | q.active);
    assign cur_pos = rx_sof ? '0 : q.pos;
    assign base_ok = rx_sof ? '1 : q.ok;

    for (genvar g = 0; g < NE; g++) begin : g_entry
        pf_entry_eval #(.WIN(WIN), .BM_W(BITMASK_W)) u_eval (
            .pat(pat_w[g]), .bmask(bmask_w[g]), .bitm(bitm_w[g]),
            .pos(cur_pos), .data(rx_byte), .ok_in(base_ok[g]),
            .ok_next(ok_next[g]), .ok_final(ok_fin[g])
        );
    end

    assign hits = ok_fin & en_w;

    pf_pick #(.NE(NE), .SEL_W(SEL_W)) u_pick (
        .hits(hits), .ring_tab(ring_w),
        .any(pick_any), .idx(pick_idx), .ring(pick_ring)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        if (take) begin
            if (rx_eof || cur_pos == POS_W'(WIN - 1)) begin
                d.active  = 1'b0;
                d.rvalid  = 1'b1;
                d.raccept = pick_any;
                d.rring   = pick_ring;
                d.rentry  = pick_idx;
            end else begin
                d.active = 1'b1;
                d.pos    = cur_pos + 1'b1;
                d.ok     = ok_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid  = q.rvalid;
    assign res_accept = q.raccept;
    assign res_ring   = q.rring;
    assign res_entry  = q.rentry;

    // R6: a verdict only follows a frame byte
    a_r6_result_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rx_valid));

    // R6: no verdict after a cycle in which no byte was taken
    a_r6_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !res_valid);

    // R11: a rejected verdict carries zero ring and entry
    a_r11_reject_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> (res_ring == '0 && res_entry == '0));

    // R10: the reported winner was enabled when the verdict was formed
    a_r10_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |->
        (($past(en_w) & ({{(NE-1){1'b0}}, 1'b1} << res_entry)) != '0));

    // R9: the picked entry is a hit and no lower entry hits
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> (hits[pick_idx] &&
        ((hits & (({{(NE-1){1'b0}}, 1'b1} << pick_idx) - 1'b1)) == '0)));

endmodule

// File: tb/pf_filter_test.sv
module pf_filter_test;

    localparam int NE  = 17;
    localparam int WIN = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_byte;
    logic        res_valid, res_accept;
    logic [1:0]  res_ring;
    logic [4:0]  res_entry;

    always #2.5 clk = ~clk;

    pf_filter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_byte(rx_byte),
        .res_valid(res_valid), .res_accept(res_accept),
        .res_ring(res_ring), .res_entry(res_entry)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // behavioural reference model state
    logic [7:0]    m_pat [NE][WIN];
    logic          m_bm  [NE][WIN];
    logic [15:0]   m_bit [NE];
    logic [1:0]    m_sel [NE];
    logic [NE-1:0] m_en;
    logic [7:0]    frame [$];
    bit            m_active;
    logic          e_valid, e_acc;
    logic [1:0]    e_ring;
    logic [4:0]    e_idx;

    // last observed verdict
    bit         got;
    logic       l_acc;
    logic [1:0] l_ring;
    logic [4:0] l_idx;

    logic [7:0] fr [0:127];

    function automatic void decide();
        e_acc = 0; e_ring = 0; e_idx = 0;
        for (int e = 0; e < NE; e++) begin
            bit ok = 1;
            if (!m_en[e]) continue;
            for (int p = 0; p < WIN; p++) begin
                logic [7:0] care;
                if (m_bm[e][p]) continue;
                if (p >= frame.size()) begin ok = 0; continue; end
                care = (p < 2) ? m_bit[e][p*8 +: 8] : 8'hFF;
                if (((frame[p] ^ m_pat[e][p]) & care) != 0) ok = 0;
            end
            if (ok) begin
                e_acc = 1; e_ring = m_sel[e]; e_idx = 5'(e);
                return;
            end
        end
    endfunction

    function automatic void model_write();
        int kind = int'(cfg_addr[11:9]);
        int ent  = int'(cfg_addr[8:4]);
        int w    = int'(cfg_addr[3:0]);
        if (kind == 4) m_en = cfg_wdata[NE-1:0];
        else if (ent < NE) begin
            case (kind)
                0: for (int i = 0; i < 4; i++) m_pat[ent][4*w+i] = cfg_wdata[8*i +: 8];
                1: if (w < 2) for (int i = 0; i < 32; i++) m_bm[ent][32*w+i] = cfg_wdata[i];
                2: m_bit[ent] = cfg_wdata[15:0];
                3: m_sel[ent] = cfg_wdata[1:0];
                default: ;
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                for (int p = 0; p < WIN; p++) begin
                    m_pat[e][p] = 8'h00;
                    m_bm[e][p]  = 1'b0;
                end
                m_bit[e] = 16'h0;
                m_sel[e] = 2'd0;
            end
            m_en = '0; m_active = 0; frame.delete();
            e_valid = 0; e_acc = 0; e_ring = 0; e_idx = 0;
        end else begin
            e_valid = 0;
            if (rx_valid && (rx_sof || m_active)) begin
                if (rx_sof) frame.delete();
                frame.push_back(rx_byte);
                if (rx_eof || frame.size() == WIN) begin
                    decide();
                    e_valid  = 1;
                    m_active = 0;
                end else begin
                    m_active = 1;
                end
            end
            if (cfg_wr) model_write();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (res_valid !== e_valid) begin
                fails++;
                $display("FAIL %s: res_valid actual=%0b expected=%0b", cur_req, res_valid, e_valid);
            end
            if (e_valid && res_valid) begin
                checks++;
                if (res_accept !== e_acc || res_ring !== e_ring || res_entry !== e_idx) begin
                    fails++;
                    $display("FAIL %s: verdict actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
                             cur_req, res_accept, res_ring, res_entry, e_acc, e_ring, e_idx);
                end
            end
            if (res_valid) begin
                got = 1; l_acc = res_accept; l_ring = res_ring; l_idx = res_entry;
            end
        end
    end

    function automatic logic [11:0] ad(int kind, int ent, int w);
        return {3'(kind), 5'(ent), 4'(w)};
    endfunction

    task automatic wr(int kind, int ent, int w, logic [31:0] data);
        cfg_wr = 1; cfg_addr = ad(kind, ent, w); cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic prog(int ent, logic [31:0] p0, logic [31:0] p1, logic [31:0] p2,
                        logic [31:0] m0, logic [31:0] m1, logic [15:0] bm, int sel);
        wr(0, ent, 0, p0); wr(0, ent, 1, p1); wr(0, ent, 2, p2);
        wr(1, ent, 0, m0); wr(1, ent, 1, m1);
        wr(2, ent, 0, {16'h0, bm}); wr(3, ent, 0, 32'(sel));
    endtask

    task automatic send_bytes(int len, bit with_eof);
        got = 0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = with_eof && (i == len - 1);
            rx_byte = fr[i];
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        if (with_eof) repeat (2) @(negedge clk);
    endtask

    task automatic send(int len);
        send_bytes(len, 1'b1);
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 128; i++) fr[i] = 8'(i * 7 + seed);
    endtask

    task automatic set_uni();
        fr[0] = 8'h02; fr[1] = 8'h11; fr[2] = 8'h22;
        fr[3] = 8'h33; fr[4] = 8'h44; fr[5] = 8'h55;
    endtask

    task automatic expect_last(logic acc, logic [1:0] ring, logic [4:0] idx, string req);
        checks++;
        if (!got || l_acc !== acc || l_ring !== ring || l_idx !== idx) begin
            fails++;
            $display("FAIL %s: last verdict actual=%0b/%0b/%0d/%0d expected=1/%0b/%0d/%0d",
                     req, got, l_acc, l_ring, l_idx, acc, ring, idx);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_wr = 0; cfg_addr = '0; cfg_wdata = '0;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_byte = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: res_valid in reset actual=%0b expected=0", res_valid);
        end
        rst_n = 1;
        @(negedge clk);

        cur_req = "R1";
        fill(3); send(20);
        expect_last(0, 0, 0, "R1");

        cur_req = "R3";
        prog(1, 32'h33221102, 32'h00005544, 32'h0, 32'hFFFF_FFC0, 32'hFFFF_FFFF, 16'hFFFF, 1);
        wr(4, 0, 0, 32'h0000_0002);
        fill(9); set_uni(); send(20);
        expect_last(1, 1, 1, "R3");

        cur_req = "R11";
        fill(9); set_uni(); fr[5] = 8'h56; send(20);
        expect_last(0, 0, 0, "R11");

        cur_req = "R2";
        wr(0, 17, 0, 32'h0); wr(3, 17, 0, 32'h3); wr(2, 17, 0, 32'h0);
        fill(9); set_uni(); send(20);
        expect_last(1, 1, 1, "R2");

        cur_req = "R4";
        prog(2, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFC0, 32'hFFFF_FFFF, 16'hFFFF, 2);
        wr(4, 0, 0, 32'h0000_0006);
        fill(1); for (int i = 0; i < 6; i++) fr[i] = 8'hFF; send(30);
        expect_last(1, 2, 2, "R4");

        cur_req = "R5";
        wr(4, 0, 0, 32'h0000_0004);
        wr(2, 1, 0, 32'h0000_FFFE);
        wr(4, 0, 0, 32'h0000_0006);
        fill(9); set_uni(); fr[0] = 8'h03; send(20);
        expect_last(1, 1, 1, "R5");
        fill(9); set_uni(); fr[0] = 8'h06; send(20);
        expect_last(0, 0, 0, "R5");

        cur_req = "R7";
        prog(3, 32'hA3A2A1A0, 32'hA7A6A5A4, 32'h0000A9A8, 32'hFFFF_FC00, 32'hFFFF_FFFF, 16'hFFFF, 3);
        wr(4, 0, 0, 32'h0000_000E);
        for (int i = 0; i < 10; i++) fr[i] = 8'(8'hA0 + i);
        send(8);
        expect_last(0, 0, 0, "R7");
        send(9);
        expect_last(0, 0, 0, "R7");
        send(10);
        expect_last(1, 3, 3, "R7");

        cur_req = "R8";
        prog(16, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 2);
        wr(4, 0, 0, 32'h0001_000E);
        fr[0] = 8'h77; send(1);
        expect_last(1, 2, 16, "R8");

        cur_req = "R9";
        fill(9); set_uni(); send(20);
        expect_last(1, 1, 1, "R9");
        for (int i = 0; i < 10; i++) fr[i] = 8'(8'hA0 + i);
        send(10);
        expect_last(1, 3, 3, "R9");

        cur_req = "R10";
        wr(4, 0, 0, 32'h0000_000E);
        fr[0] = 8'h77; send(1);
        expect_last(0, 0, 0, "R10");
        wr(4, 0, 0, 32'h0001_000C);
        fill(9); set_uni(); send(20);
        expect_last(1, 2, 16, "R10");

        cur_req = "R6";
        wr(0, 4, 15, 32'hA500_0000);
        wr(1, 4, 0, 32'hFFFF_FFFF); wr(1, 4, 1, 32'h7FFF_FFFF);
        wr(2, 4, 0, 32'h0000_FFFF); wr(3, 4, 0, 32'h0);
        wr(4, 0, 0, 32'h0000_0010);
        fill(5); fr[63] = 8'hA5; send(70);
        expect_last(1, 0, 4, "R6");
        fill(5); fr[63] = 8'hA4; send(70);
        expect_last(0, 0, 0, "R6");
        fill(5); fr[63] = 8'hA5; send_bytes(5, 1'b0);
        fill(5); fr[63] = 8'hA5; send(70);
        expect_last(1, 0, 4, "R6");

        cur_req = "R7";
        fill(5); send(63);
        expect_last(0, 0, 0, "R7");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule